// File: doc/BRIEF.md
# Serial Acknowledge Interrupt Priority Resolver

This block settles which of several interrupting devices is served when the processor acknowledges an interrupt. The stages sit in a row, and the acknowledge runs through them one after another. Stage 0 sees the processor's acknowledge first. Each later stage sees only what the stage before it lets through. A stage that has a request waiting keeps the acknowledge for itself and stops it from going further. A stage with nothing waiting passes it on. So priority comes only from position in the row. The stage that receives the acknowledge and does not pass it on is the winner. The winner places its own vector address on the shared data output.

Requests are held as they arrive, in a set of pending flags. The combined request to the processor is raised while any request is present. When the acknowledge rises, the block copies the set of waiting requests. It then resolves the winner from that copy alone. As a result, a request that arrives during the acknowledge cannot move the grant. When the acknowledge falls, the processor has read the vector, so the winning stage's pending flag is cleared.

Top module: `intr_chain_resolver`

## Requirements
- R1: When the acknowledge is active and no stage in the captured set has a request, every stage passes it on. `pri_out_last` is then 1, `grant_vec` is 0 and `data_out` is 0.
- R2: When the acknowledge is not active (`cpu_ack` was 0 at the previous rising clock edge), no stage receives it. `pri_out_last` is 0, `grant_vec` is 0 and `data_out` is 0, whatever requests are pending.
- R3: A stage that receives the acknowledge and has a captured request stops it. No stage further along the row receives it, so `pri_out_last` is 0 whenever any stage is granting.
- R4: At most one bit of `grant_vec` is set. Bit i means stage i is the winner. During an acknowledge, the winner is the stage with the lowest index among the captured requests, since stage 0 is nearest the processor.
- R5: `data_out` carries the vector of the winning stage. The vector of stage i is field i of `VEC_TABLE`, that is bits [i*VEC_W +: VEC_W]. The default vectors are 0x20, 0x24, 0x28 and 0x2C for stages 0 to 3. `data_out` is 0 while no stage is granting.
- R6: `irq_out` is 1 while any `dev_req` bit is 1 or any pending flag is set. A one-cycle request pulse sets a pending flag, and that flag holds `irq_out` high until the request is served.
- R7: The winner is resolved from the requests captured at the clock edge where `cpu_ack` is first seen as 1. A request that arrives later in the same acknowledge does not change `grant_vec` or `data_out`, but it is still held as pending.
- R8: At the clock edge where `cpu_ack` is first seen as 0 after an acknowledge, the winner's pending flag is cleared. Every other pending flag is kept, so repeated acknowledges serve the requests in order of position.
- R9: The grant and the vector appear at the first rising edge that samples `cpu_ack` as 1. They are removed at the first rising edge that samples it as 0.
- R10: While `rst_n` is low, all pending flags and the captured set are cleared. `irq_out`, `grant_vec`, `data_out` and `pri_out_last` are then 0 when `dev_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| dev_req | input | N_STAGES | Request from each device; bit 0 has the highest priority |
| cpu_ack | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Combined interrupt request to the processor |
| data_out | output | VEC_W | Vector of the winning stage, 0 when there is no winner |
| grant_vec | output | N_STAGES | One-hot marker of the stage that holds the acknowledge |
| pri_out_last | output | 1 | Acknowledge as it leaves the last stage of the row |

## Verification
The bench covers several kinds of request pattern:
- A single request, to catch a fixed or off-by-one priority.
- Requests from two or more stages, to catch a design that lets two stages drive the bus or picks the stage at the far end of the row.
- A request that arrives during an acknowledge, to catch a design that resolves the winner without a captured copy, which would switch vectors in the middle of a cycle.

Draining each pattern through repeated acknowledges exposes two further faults. A design that clears every flag would lose the requests still waiting. A design that clears no flag would grant the same stage again. An acknowledge with nothing pending checks that the acknowledge passes to the end of the row and that the bus stays at zero.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_RISE,
        ACK_HOLD,
        ACK_FALL
    } ack_phase_e;

    // Classify the acknowledge from its registered and present values.
    function automatic ack_phase_e ack_phase(input logic prev_ack, input logic cur_ack);
        ack_phase_e ph;
        case ({prev_ack, cur_ack})
            2'b01:   ph = ACK_RISE;
            2'b11:   ph = ACK_HOLD;
            2'b10:   ph = ACK_FALL;
            default: ph = ACK_IDLE;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/irq_stage.sv
module irq_stage (
    input  logic pri_in,
    input  logic req_held,
    output logic pri_out,
    output logic grant
);
    // A waiting request absorbs the acknowledge; otherwise it passes on.
    always_comb begin
        grant   = pri_in & req_held;
        pri_out = pri_in & ~req_held;
    end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8,
    parameter logic [N_STAGES*VEC_W-1:0] VEC_TABLE = '0
) (
    input  logic [N_STAGES-1:0] grant,
    output logic [VEC_W-1:0]    vec
);
    logic [VEC_W-1:0] masked [N_STAGES];

    genvar g;
    generate
        for (g = 0; g < N_STAGES; g++) begin : g_mask
            assign masked[g] = grant[g] ? VEC_TABLE[g*VEC_W +: VEC_W] : '0;
        end
    endgenerate

    // The grant is one-hot, so OR-ing the masked vectors selects one.
    always_comb begin
        vec = '0;
        for (int i = 0; i < N_STAGES; i++) begin
            vec = vec | masked[i];
        end
    end
endmodule

// File: rtl/intr_chain_resolver.sv
module intr_chain_resolver
    import irq_chain_pkg::*;
#(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8,
    parameter logic [N_STAGES*VEC_W-1:0] VEC_TABLE = {8'h2C, 8'h28, 8'h24, 8'h20}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] dev_req,
    input  logic                cpu_ack,
    output logic                irq_out,
    output logic [VEC_W-1:0]    data_out,
    output logic [N_STAGES-1:0] grant_vec,
    output logic                pri_out_last
);
    localparam int LAST = N_STAGES - 1;

    typedef struct packed {
        logic                ack;
        logic [N_STAGES-1:0] snap;
        logic [N_STAGES-1:0] pend;
    } state_t;

    state_t     st_d, st_q;
    ack_phase_e phase;

    logic [N_STAGES-1:0] pri_in;
    logic [N_STAGES-1:0] pri_out;
    logic [N_STAGES-1:0] grant;

    // Acknowledge enters stage 0 and runs along the row.
    assign pri_in[0] = st_q.ack;

    genvar s;
    generate
        for (s = 0; s < N_STAGES; s++) begin : g_stage
            irq_stage u_stage (
                .pri_in   (pri_in[s]),
                .req_held (st_q.snap[s]),
                .pri_out  (pri_out[s]),
                .grant    (grant[s])
            );
            if (s < LAST) begin : g_link
                assign pri_in[s+1] = pri_out[s];
            end
        end
    endgenerate

    irq_vec_mux #(
        .N_STAGES  (N_STAGES),
        .VEC_W     (VEC_W),
        .VEC_TABLE (VEC_TABLE)
    ) u_mux (
        .grant (grant),
        .vec   (data_out)
    );

    always_comb begin
        st_d     = st_q;
        phase    = ack_phase(st_q.ack, cpu_ack);
        st_d.ack = cpu_ack;
        st_d.pend = st_q.pend | dev_req;
        case (phase)
            ACK_RISE: st_d.snap = st_q.pend | dev_req;
            ACK_FALL: begin
                st_d.pend = (st_q.pend & ~grant) | dev_req;
                st_d.snap = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out      = |(st_q.pend | dev_req);
    assign grant_vec    = grant;
    assign pri_out_last = pri_out[LAST];

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
    parameter int N_STAGES = 4,
    parameter int VEC_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_STAGES-1:0] dev_req,
    input logic                cpu_ack,
    input logic                irq_out,
    input logic [VEC_W-1:0]    data_out,
    input logic [N_STAGES-1:0] grant_vec,
    input logic                pri_out_last,
    input logic                ack_q,
    input logic [N_STAGES-1:0] pend_q
);
    p_onehot_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ack |=> (grant_vec == '0 && !pri_out_last && data_out == '0));

    p_data_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec == '0) |-> (data_out == '0));

    p_block_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vec != '0) |-> !pri_out_last);

    p_winner_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && $past(cpu_ack)) |=> $stable(grant_vec));

    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req != '0) |-> irq_out);

    p_clear_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !cpu_ack && grant_vec != '0 && (grant_vec & dev_req) == '0)
        |=> ((pend_q & $past(grant_vec)) == '0));
endmodule

bind intr_chain_resolver irq_chain_chk #(
    .N_STAGES (N_STAGES),
    .VEC_W    (VEC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_req      (dev_req),
    .cpu_ack      (cpu_ack),
    .irq_out      (irq_out),
    .data_out     (data_out),
    .grant_vec    (grant_vec),
    .pri_out_last (pri_out_last),
    .ack_q        (st_q.ack),
    .pend_q       (st_q.pend)
);

// File: tb/sim_intr_chain_resolver.sv
`timescale 1ns/1ps
module sim_intr_chain_resolver;
    localparam int N = 4;
    localparam int W = 8;
    localparam logic [N*W-1:0] VECS = {8'h2C, 8'h28, 8'h24, 8'h20};

    // {request pattern[6:3], expected first winner[2:0]}
    localparam logic [6:0] TBL [8] = '{
        {4'b0001, 3'd0}, {4'b0010, 3'd1}, {4'b1000, 3'd3}, {4'b1010, 3'd1},
        {4'b0110, 3'd1}, {4'b1111, 3'd0}, {4'b1100, 3'd2}, {4'b0100, 3'd2}
    };

    logic         clk = 0;
    logic         rst_n = 0;
    logic [N-1:0] dev_req = '0;
    logic         cpu_ack = 0;
    logic         irq_out;
    logic [W-1:0] data_out;
    logic [N-1:0] grant_vec;
    logic         pri_out_last;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    intr_chain_resolver #(.N_STAGES(N), .VEC_W(W), .VEC_TABLE(VECS)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack),
        .irq_out(irq_out), .data_out(data_out), .grant_vec(grant_vec),
        .pri_out_last(pri_out_last)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_req(input logic [N-1:0] pat);
        @(negedge clk); dev_req = pat;
        tick();
        @(negedge clk); dev_req = '0;
    endtask

    task automatic ack_on();
        @(negedge clk); cpu_ack = 1;
        tick();
    endtask

    task automatic ack_off();
        @(negedge clk); cpu_ack = 0;
        tick();
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return N;
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk("R10 irq", irq_out, 0);
        chk("R10 grant", grant_vec, 0);
        chk("R10 data", data_out, 0);
        chk("R10 pri_last", pri_out_last, 0);
        @(negedge clk); rst_n = 1;
        tick();

        // Table walk: capture, grant, then drain in order of position
        for (int t = 0; t < 8; t++) begin
            logic [N-1:0] rem;
            int first;
            rem   = TBL[t][6:3];
            first = 1;
            pulse_req(rem);
            tick();
            chk("R6 irq held by pulse", irq_out, 1);
            chk("R2 no grant before ack", grant_vec, 0);
            while (rem != '0) begin
                int w;
                w = lowest(rem);
                if (first) chk("R4 table winner", w, TBL[t][2:0]);
                first = 0;
                ack_on();
                chk("R4 grant onehot", grant_vec, 1 << w);
                chk("R5 vector", data_out, VECS[w*W +: W]);
                chk("R3 tail blocked", pri_out_last, 0);
                ack_off();
                rem[w] = 1'b0;
                chk("R9 grant removed", grant_vec, 0);
                chk("R8 rest kept", irq_out, rem != '0);
            end
        end

        // R1: acknowledge with nothing pending passes to the end
        ack_on();
        chk("R1 pri_last", pri_out_last, 1);
        chk("R1 grant", grant_vec, 0);
        chk("R1 data", data_out, 0);
        ack_off();
        chk("R2 pri_last idle", pri_out_last, 0);

        // R7: late request during acknowledge does not move the winner
        pulse_req(4'b1000);
        ack_on();
        chk("R7 initial winner", grant_vec, 4'b1000);
        @(negedge clk); dev_req = 4'b0001;
        tick();
        @(negedge clk); dev_req = '0;
        tick();
        chk("R7 winner kept", grant_vec, 4'b1000);
        chk("R7 vector kept", data_out, 8'h2C);
        ack_off();
        chk("R7 late request pending", irq_out, 1);
        ack_on();
        chk("R7 late served", grant_vec, 4'b0001);
        chk("R7 late vector", data_out, 8'h20);
        ack_off();
        chk("R8 all served", irq_out, 0);

        // R9: latency of grant relative to ack
        pulse_req(4'b0100);
        @(negedge clk); cpu_ack = 1;
        #1;
        chk("R9 not before edge", grant_vec, 0);
        tick();
        chk("R9 after edge", grant_vec, 4'b0100);
        ack_off();

        // R6: raw request raises irq combinationally
        @(negedge clk); dev_req = 4'b0010;
        #1;
        chk("R6 raw request", irq_out, 1);
        @(negedge clk); dev_req = '0;
        ack_on(); ack_off();

        // R10: reset clears pending
        pulse_req(4'b0011);
        @(negedge clk); rst_n = 0;
        #1;
        chk("R10 pend cleared", irq_out, 0);
        @(negedge clk); rst_n = 1;
        tick();
        chk("R10 still clear", irq_out, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule